// File: doc/BRIEF.md
# Watch-Mode Clock Gating and Wake Sequencer

This block puts a microcontroller clock generator into a low-power watch state and brings it back out. On a request from run state it turns off the CPU-system, internal-bus and general peripheral clock enables. It also shuts down the PLL and the spread-spectrum generator. The oscillator enables during the watch state follow configuration bits that are captured when the state is entered. Oscillators appear only as enable outputs. Clock multiplexing itself sits outside the block, which drives an encoded CPU source select and a peripheral source select.

While in watch, the block samples three groups of wake sources: unmasked maskable interrupts, the two non-maskable interrupts, and the four reset sources. An ordinary wake picks the CPU source and the peripheral source from the captured oscillator-disable and sub-clock-select bits. The CPU source is the main oscillator when oscillators stay enabled. Otherwise it is the sub-clock chosen before entry, and the peripheral clock then runs from the ring oscillator. If the ring oscillator was stopped before entry and is now needed, a programmable settling count on the always-on slow clock runs before the clocks are handed back. A reset wake skips all of this: the block returns to run with default selections on the next edge.

Top module: `watch_clk_ctrl`

## Requirements
- R1: After reset the block is in run state: `cpu_clk_en`, `bus_clk_en` and `per_clk_en` are 1, `cpu_src` is 2'b00 (main), `per_src` is 0 (main), and `pll_en` follows `pll_req`.
- R2: A high `enter_req` in run state is accepted at a clock edge, and the three clock enables read 0 after that edge. `enter_req` has no effect in any other state.
- R3: On entry `pll_en` and `spread_en` go to 0 and stay 0 after an ordinary wake, even while their requests stay high. Each one follows its request again only after that request has been low for at least one run-state edge.
- R4: In watch, `main_osc_en` is 0 when `cfg_osc_off` was 1 at entry and 1 otherwise. `ring_osc_en` is 0 when `cfg_ring_stop` was 1 at entry and 1 otherwise. `sub_osc_en` is always 1.
- R5: In watch, a wake is caused by any bit of `irq_pend` whose `irq_mask` bit is 0, by either bit of `nmi`, or by any bit of `rst_src`. A pending interrupt whose mask bit is 1 leaves the block in watch.
- R6: After an ordinary wake, `cpu_src` is 2'b00 (main) if the captured `cfg_osc_off` was 0. If it was 1, `cpu_src` is 2'b01 (ring) when the captured `cfg_sub_sel` was 0 and 2'b10 (sub) when it was 1.
- R7: After an ordinary wake, `per_src` equals the captured `cfg_osc_off`, where 0 selects main and 1 selects ring.
- R8: If both `cfg_ring_stop` and `cfg_osc_off` were 1 at entry, the clock enables rise `stab_len`+3 edges after the wake edge, and `ring_osc_en` is 1 during the wait. Otherwise they rise 2 edges after the wake edge.
- R9: Any bit of `rst_src` puts the block in run state at the next edge from every state, including during the settling wait. `cpu_src` and `per_src` then return to main and both PLL-type enables follow their requests again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Request to enter watch state |
| cfg_osc_off | input | 1 | Main oscillator disable in watch |
| cfg_ring_stop | input | 1 | Ring oscillator stop bit |
| cfg_sub_sel | input | 1 | Sub-clock choice: 0 ring, 1 sub oscillator |
| stab_len | input | CW | Ring oscillator settling count |
| irq_pend | input | NIRQ | Pending maskable wake interrupts |
| irq_mask | input | NIRQ | Interrupt mask, 1 = masked |
| nmi | input | 2 | Non-maskable interrupts |
| rst_src | input | 4 | Reset wake sources |
| pll_req | input | 1 | PLL enable request |
| spread_req | input | 1 | Spread-spectrum generator enable request |
| cpu_clk_en | output | 1 | CPU-system clock enable |
| bus_clk_en | output | 1 | Internal bus clock enable |
| per_clk_en | output | 1 | General peripheral clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| ring_osc_en | output | 1 | Ring oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| pll_en | output | 1 | PLL enable |
| spread_en | output | 1 | Spread-spectrum generator enable |
| cpu_src | output | 2 | CPU source: 00 main, 01 ring, 10 sub |
| per_src | output | 1 | Peripheral source: 0 main, 1 ring |

## Verification
The assertions check on every cycle the step-by-step rules: clocks drop the edge after an accepted entry, the main oscillator drops on entry when disabled, the settling wait does not end early, a reset wake returns to run with main selected, and the PLL stays off as the block comes out of resume. The bench scenarios cover what needs a full sequence. These are the latency from wake to restored clocks with and without the settling wait, each source-selection combination, masked interrupts that must not wake the block, and re-arming the PLL and spread-spectrum enables by dropping and reissuing their requests.

// File: rtl/watch_clk_ctrl.sv
module watch_clk_ctrl #(
  parameter int NIRQ = 8,
  parameter int CW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_req,
  input  logic            cfg_osc_off,
  input  logic            cfg_ring_stop,
  input  logic            cfg_sub_sel,
  input  logic [CW-1:0]   stab_len,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_mask,
  input  logic [1:0]      nmi,
  input  logic [3:0]      rst_src,
  input  logic            pll_req,
  input  logic            spread_req,
  output logic            cpu_clk_en,
  output logic            bus_clk_en,
  output logic            per_clk_en,
  output logic            main_osc_en,
  output logic            ring_osc_en,
  output logic            sub_osc_en,
  output logic            pll_en,
  output logic            spread_en,
  output logic [1:0]      cpu_src,
  output logic            per_src
);

  typedef enum logic [1:0] {S_RUN, S_WATCH, S_STAB, S_RESUME} state_t;

  localparam logic [1:0] SRC_MAIN = 2'b00;
  localparam logic [1:0] SRC_RING = 2'b01;
  localparam logic [1:0] SRC_SUB  = 2'b10;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          off_q, ring_stop_q, sub_q;
  logic          pll_arm, spread_arm;

  logic in_run, any_rst, wake, need_wait;
  logic [1:0] wake_src;

  assign in_run    = (state == S_RUN);
  assign any_rst   = |rst_src;
  assign wake      = |(irq_pend & ~irq_mask) | (|nmi);
  assign need_wait = off_q & ring_stop_q;
  assign wake_src  = off_q ? (sub_q ? SRC_SUB : SRC_RING) : SRC_MAIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_RUN;
      cnt         <= '0;
      off_q       <= 1'b0;
      ring_stop_q <= 1'b0;
      sub_q       <= 1'b0;
      cpu_src     <= SRC_MAIN;
      per_src     <= 1'b0;
      pll_arm     <= 1'b1;
      spread_arm  <= 1'b1;
    end else if (any_rst) begin
      state      <= S_RUN;
      cpu_src    <= SRC_MAIN;
      per_src    <= 1'b0;
      pll_arm    <= 1'b1;
      spread_arm <= 1'b1;
    end else begin
      case (state)
        S_RUN: begin
          if (!pll_req)    pll_arm    <= 1'b1;
          if (!spread_req) spread_arm <= 1'b1;
          if (enter_req) begin
            state       <= S_WATCH;
            off_q       <= cfg_osc_off;
            ring_stop_q <= cfg_ring_stop;
            sub_q       <= cfg_sub_sel;
            pll_arm     <= 1'b0;
            spread_arm  <= 1'b0;
          end
        end
        S_WATCH: begin
          if (wake) begin
            if (need_wait) begin
              state <= S_STAB;
              cnt   <= stab_len;
            end else begin
              state   <= S_RESUME;
              cpu_src <= wake_src;
              per_src <= off_q;
            end
          end
        end
        S_STAB: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            state   <= S_RESUME;
            cpu_src <= wake_src;
            per_src <= off_q;
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end

  assign cpu_clk_en  = in_run;
  assign bus_clk_en  = in_run;
  assign per_clk_en  = in_run;
  assign sub_osc_en  = 1'b1;
  assign main_osc_en = in_run | ~off_q;
  assign ring_osc_en = (state == S_WATCH) ? ~ring_stop_q :
                       (state == S_STAB)  ? 1'b1 :
                       (~cfg_ring_stop | (cpu_src == SRC_RING) | per_src);
  assign pll_en      = in_run & pll_arm & pll_req;
  assign spread_en   = in_run & spread_arm & spread_req;

  a_r2_gate_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && enter_req && !any_rst) |=> (!cpu_clk_en && !bus_clk_en && !per_clk_en));

  a_r4_main_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && enter_req && cfg_osc_off && !any_rst) |=> !main_osc_en);

  a_r8_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STAB && cnt != '0 && !any_rst) |=> (state == S_STAB && !cpu_clk_en));

  a_r9_reset_wake: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |=> (cpu_clk_en && cpu_src == SRC_MAIN && !per_src));

  a_r3_pll_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RESUME && !any_rst) |=> (!pll_en && !spread_en));

  a_r5_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WATCH && !wake && !any_rst) |=> (state == S_WATCH));

endmodule

// File: tb/sim_watch_clk_ctrl.sv
module sim_watch_clk_ctrl;
  localparam int NIRQ = 8;
  localparam int CW   = 12;

  logic clk = 0, rst_n = 0;
  logic enter_req = 0, cfg_osc_off = 0, cfg_ring_stop = 0, cfg_sub_sel = 0;
  logic [CW-1:0] stab_len = 5;
  logic [NIRQ-1:0] irq_pend = 0, irq_mask = '1;
  logic [1:0] nmi = 0;
  logic [3:0] rst_src = 0;
  logic pll_req = 0, spread_req = 0;
  logic cpu_clk_en, bus_clk_en, per_clk_en, main_osc_en, ring_osc_en, sub_osc_en;
  logic pll_en, spread_en, per_src;
  logic [1:0] cpu_src;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  watch_clk_ctrl #(.NIRQ(NIRQ), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .cfg_osc_off(cfg_osc_off),
    .cfg_ring_stop(cfg_ring_stop), .cfg_sub_sel(cfg_sub_sel), .stab_len(stab_len),
    .irq_pend(irq_pend), .irq_mask(irq_mask), .nmi(nmi), .rst_src(rst_src),
    .pll_req(pll_req), .spread_req(spread_req), .cpu_clk_en(cpu_clk_en),
    .bus_clk_en(bus_clk_en), .per_clk_en(per_clk_en), .main_osc_en(main_osc_en),
    .ring_osc_en(ring_osc_en), .sub_osc_en(sub_osc_en), .pll_en(pll_en),
    .spread_en(spread_en), .cpu_src(cpu_src), .per_src(per_src));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(input logic off, input logic rstop, input logic sub);
    cfg_osc_off = off; cfg_ring_stop = rstop; cfg_sub_sel = sub;
    enter_req = 1; step(1); enter_req = 0;
  endtask

  task automatic t_reset;
    pll_req = 1; #1;
    chk("R1 clocks", {cpu_clk_en, bus_clk_en, per_clk_en}, 3'b111);
    chk("R1 src", {cpu_src, per_src}, 3'b000);
    chk("R1 pll", pll_en, 1);
    pll_req = 0;
  endtask

  task automatic t_wake_main;
    pll_req = 1; spread_req = 1; step(1);
    enter(0, 0, 0);
    chk("R2 gated", {cpu_clk_en, bus_clk_en, per_clk_en}, 3'b000);
    chk("R3 off", {pll_en, spread_en}, 2'b00);
    chk("R4 osc", {main_osc_en, ring_osc_en, sub_osc_en}, 3'b111);
    irq_pend = 8'h04; irq_mask = 8'hFB; step(1); irq_pend = 0; irq_mask = '1;
    chk("R8 not yet", cpu_clk_en, 0);
    chk("R6 main", cpu_src, 2'b00);
    chk("R7 main", per_src, 0);
    step(1);
    chk("R8 two edges", cpu_clk_en, 1);
    chk("R3 stays off", {pll_en, spread_en}, 2'b00);
    step(3);
    chk("R3 still off", pll_en, 0);
    pll_req = 0; spread_req = 0; step(1);
    pll_req = 1; spread_req = 1; #1;
    chk("R3 rearm", {pll_en, spread_en}, 2'b11);
    pll_req = 0; spread_req = 0;
  endtask

  task automatic t_masked_then_nmi_sub;
    enter(1, 0, 1);
    chk("R4 main off", main_osc_en, 0);
    chk("R4 ring on", ring_osc_en, 1);
    irq_pend = 8'hFF; irq_mask = 8'hFF; enter_req = 1; step(4);
    chk("R5 masked", cpu_clk_en, 0);
    chk("R5 masked src", cpu_src, 2'b00);
    irq_pend = 0; nmi = 2'b10; step(1); nmi = 0;
    chk("R6 sub", cpu_src, 2'b10);
    chk("R7 ring", per_src, 1);
    enter_req = 0; step(1);
    chk("R2 no reentry", cpu_clk_en, 1);
  endtask

  task automatic t_ring_wait;
    int edges = 0;
    stab_len = 5;
    enter(1, 1, 0);
    chk("R4 ring stopped", ring_osc_en, 0);
    nmi = 2'b01; step(1); nmi = 0; edges = 1;
    chk("R8 ring on in wait", ring_osc_en, 1);
    while (!cpu_clk_en && edges < 40) begin step(1); edges++; end
    chk("R8 wait length", edges, 5 + 3);
    chk("R6 ring", cpu_src, 2'b01);
    chk("R7 ring per", per_src, 1);
  endtask

  task automatic t_reset_wake;
    enter(1, 0, 1);
    rst_src = 4'b0100; step(1); rst_src = 0;
    chk("R9 from watch", {cpu_clk_en, cpu_src, per_src}, 4'b1000);
    stab_len = 20;
    enter(1, 1, 1);
    nmi = 2'b01; step(3); nmi = 0;
    chk("R8 waiting", cpu_clk_en, 0);
    rst_src = 4'b0001; pll_req = 1; step(1); rst_src = 0; #1;
    chk("R9 from wait", {cpu_clk_en, cpu_src, per_src}, 4'b1000);
    chk("R9 pll armed", pll_en, 1);
    pll_req = 0;
  endtask

  initial begin
    step(2); rst_n = 1; step(1);
    t_reset;
    t_wake_main;
    t_masked_then_nmi_sub;
    t_ring_wait;
    t_reset_wake;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule